// File: doc/BRIEF.md
# Privileged Trap Return Unit

This block carries out the two privileged return operations of a small core whose status word holds a three-deep stack of privilege levels and interrupt enables. The first operation hands control from machine mode to supervisor mode. It copies the machine trap record into the supervisor trap registers and continues at the supervisor trap vector. The second is an exception return. It picks the saved PC that belongs to the current privilege, pops the privilege stack and resumes at that PC.

Each request is one strobe with an operation code, the current PC, the status word and the trap registers it needs. One cycle later the block returns a registered result. The result is exactly one of three outcomes: a commit carrying a new PC and CSR values with write enables, an illegal-instruction flag, or an instruction-address-misaligned request with its faulting address. The block checks that the target is word aligned before it writes any state, so a failed return leaves every CSR as it was. The CSR storage, instruction decode and trap entry are outside the block.

Top module: `priv_return_unit`

## Requirements
- R1: Every cycle with `req_valid` high produces `done` high in the next cycle, and with it exactly one of `commit`, `illegal`, `misaligned`.
- R2: The status word holds these fields: IE at bit 0, PRV at bits 2:1, IE1 at bit 3, PRV1 at bits 5:4, IE2 at bit 6 and PRV2 at bits 8:7. Privilege codes are user 0, supervisor 1, hypervisor 2, machine 3. `req_op` = 0 requests the machine-to-supervisor redirect. The redirect is illegal unless PRV is 3. An illegal request raises `illegal`, asserts no write enable, and returns `next_pc` equal to the current PC.
- R3: A legal, aligned redirect asserts `s_trap_we` and drives the machine bad address, cause and EPC onto `s_badaddr_out`, `s_cause_out` and `s_epc_out`. It also asserts `status_we` with PRV set to 1 and every other status bit unchanged.
- R4: The redirect target is `s_tvec`. If either of its two low bits is set, the block raises `misaligned`, sets `fault_addr` and `next_pc` to the current PC, and asserts no write enable. Otherwise `next_pc` is `s_tvec`.
- R5: `req_op` = 1 requests the exception return. It is illegal when PRV is 0 (user) or 2 (hypervisor).
- R6: The return target is `s_epc` when PRV is 1 and `m_epc` when PRV is 3. The EPC of the other level has no effect on the result.
- R7: If either of the return target's two low bits is set, the block raises `misaligned` with `fault_addr` and `next_pc` equal to the current PC, and asserts no write enable.
- R8: A successful return sets `next_pc` to the target and asserts `status_we`. The new status has PRV←PRV1, IE←IE1, PRV1←PRV2, IE1←IE2, PRV2←0 and IE2←1, with bits above 8 unchanged. `s_trap_we` stays low.
- R9: While `rst` is high, all outcome flags and write enables are low and `next_pc` is 0. A request made during reset is dropped.
- R10: In a cycle that follows no request, `done`, every outcome flag and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 0 = redirect to supervisor, 1 = exception return |
| cur_pc | input | XLEN | PC of the return instruction |
| status_in | input | XLEN | Current status word |
| m_epc | input | XLEN | Machine saved PC |
| m_cause | input | XLEN | Machine trap cause |
| m_badaddr | input | XLEN | Machine bad address |
| s_epc | input | XLEN | Supervisor saved PC |
| s_tvec | input | XLEN | Supervisor trap vector |
| done | output | 1 | Result valid pulse |
| commit | output | 1 | Operation completed |
| illegal | output | 1 | Illegal-instruction flag |
| misaligned | output | 1 | Misaligned-fetch exception request |
| next_pc | output | XLEN | PC to continue from |
| fault_addr | output | XLEN | Bad address for the misaligned exception |
| status_we | output | 1 | Write enable for status_out |
| status_out | output | XLEN | New status word |
| s_trap_we | output | 1 | Write enable for the three supervisor copies |
| s_epc_out | output | XLEN | New supervisor EPC |
| s_cause_out | output | XLEN | New supervisor cause |
| s_badaddr_out | output | XLEN | New supervisor bad address |

## Verification
The bench targets targets with only bit 0 or only bit 1 set. A design that tests a single low bit would commit to an unaligned PC. A design that wrote state before the alignment check would show a write enable next to `misaligned`. It runs returns from hypervisor level, which a `>= supervisor` test wrongly accepts. It also runs returns where only the EPC of the other privilege is misaligned, which catches a swapped EPC select. Stack pops with distinct values in every field expose a field moved to the wrong place or a bottom entry left unrefilled.

// File: rtl/prt_pkg.sv
package prt_pkg;

  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_HYPER = 2'd2,
    PRV_MACH  = 2'd3
  } priv_e;

  typedef enum logic {
    OP_TO_SUPER = 1'b0,
    OP_XRET     = 1'b1
  } op_e;

  // status stack field positions (adjacent from bit 0)
  localparam int unsigned PRV_W    = 2;
  localparam int unsigned IE0_BIT  = 0;
  localparam int unsigned PRV0_LO  = IE0_BIT + 1;
  localparam int unsigned IE1_BIT  = PRV0_LO + PRV_W;
  localparam int unsigned PRV1_LO  = IE1_BIT + 1;
  localparam int unsigned IE2_BIT  = PRV1_LO + PRV_W;
  localparam int unsigned PRV2_LO  = IE2_BIT + 1;
  localparam int unsigned STACK_W  = PRV2_LO + PRV_W;

endpackage

// File: rtl/prt_target_sel.sv
module prt_target_sel
  import prt_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  op_e              op,
  input  priv_e            prv,
  input  logic [XLEN-1:0]  tvec,
  input  logic [XLEN-1:0]  sv_epc,
  input  logic [XLEN-1:0]  mc_epc,
  output logic             legal,
  output logic             aligned,
  output logic [XLEN-1:0]  target
);

  always_comb begin
    legal  = 1'b0;
    target = tvec;
    unique case (op)
      OP_TO_SUPER: begin
        legal  = (prv == PRV_MACH);
        target = tvec;
      end
      OP_XRET: begin
        unique case (prv)
          PRV_SUPER: begin
            legal  = 1'b1;
            target = sv_epc;
          end
          PRV_MACH: begin
            legal  = 1'b1;
            target = mc_epc;
          end
          default: begin
            legal  = 1'b0;
            target = sv_epc;
          end
        endcase
      end
      default: begin
        legal  = 1'b0;
        target = tvec;
      end
    endcase
  end

  assign aligned = (target[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/prt_stack_pop.sv
module prt_stack_pop
  import prt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] st_in,
  output logic [XLEN-1:0] st_popped
);

  always_comb begin
    st_popped                   = st_in;
    st_popped[IE0_BIT]          = st_in[IE1_BIT];
    st_popped[PRV0_LO +: PRV_W] = st_in[PRV1_LO +: PRV_W];
    st_popped[IE1_BIT]          = st_in[IE2_BIT];
    st_popped[PRV1_LO +: PRV_W] = st_in[PRV2_LO +: PRV_W];
    st_popped[IE2_BIT]          = 1'b1;
    st_popped[PRV2_LO +: PRV_W] = PRV_USER;
  end

endmodule

// File: rtl/prt_priv_set.sv
module prt_priv_set
  import prt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] st_in,
  input  priv_e           new_prv,
  output logic [XLEN-1:0] st_out
);

  always_comb begin
    st_out                   = st_in;
    st_out[PRV0_LO +: PRV_W] = new_prv;
  end

endmodule

// File: rtl/priv_return_unit.sv
module priv_return_unit
  import prt_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_op,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] status_in,
  input  logic [XLEN-1:0] m_epc,
  input  logic [XLEN-1:0] m_cause,
  input  logic [XLEN-1:0] m_badaddr,
  input  logic [XLEN-1:0] s_epc,
  input  logic [XLEN-1:0] s_tvec,
  output logic            done,
  output logic            commit,
  output logic            illegal,
  output logic            misaligned,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] fault_addr,
  output logic            status_we,
  output logic [XLEN-1:0] status_out,
  output logic            s_trap_we,
  output logic [XLEN-1:0] s_epc_out,
  output logic [XLEN-1:0] s_cause_out,
  output logic [XLEN-1:0] s_badaddr_out
);

  op_e             op;
  priv_e           cur_prv;
  logic            legal;
  logic            aligned;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] st_popped;
  logic [XLEN-1:0] st_super;

  assign op      = op_e'(req_op);
  assign cur_prv = priv_e'(status_in[PRV0_LO +: PRV_W]);

  prt_target_sel #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_sel (
    .op      (op),
    .prv     (cur_prv),
    .tvec    (s_tvec),
    .sv_epc  (s_epc),
    .mc_epc  (m_epc),
    .legal   (legal),
    .aligned (aligned),
    .target  (target)
  );

  prt_stack_pop #(.XLEN(XLEN)) u_pop (
    .st_in     (status_in),
    .st_popped (st_popped)
  );

  prt_priv_set #(.XLEN(XLEN)) u_set (
    .st_in   (status_in),
    .new_prv (PRV_SUPER),
    .st_out  (st_super)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done          <= 1'b0;
      commit        <= 1'b0;
      illegal       <= 1'b0;
      misaligned    <= 1'b0;
      status_we     <= 1'b0;
      s_trap_we     <= 1'b0;
      next_pc       <= '0;
      fault_addr    <= '0;
      status_out    <= '0;
      s_epc_out     <= '0;
      s_cause_out   <= '0;
      s_badaddr_out <= '0;
    end else begin
      done       <= req_valid;
      commit     <= 1'b0;
      illegal    <= 1'b0;
      misaligned <= 1'b0;
      status_we  <= 1'b0;
      s_trap_we  <= 1'b0;
      if (req_valid) begin
        next_pc <= cur_pc;
        if (!legal) begin
          illegal <= 1'b1;
        end else if (!aligned) begin
          misaligned <= 1'b1;
          fault_addr <= cur_pc;
        end else begin
          commit    <= 1'b1;
          next_pc   <= target;
          status_we <= 1'b1;
          if (op == OP_TO_SUPER) begin
            status_out    <= st_super;
            s_trap_we     <= 1'b1;
            s_epc_out     <= m_epc;
            s_cause_out   <= m_cause;
            s_badaddr_out <= m_badaddr;
          end else begin
            status_out <= st_popped;
          end
        end
      end
    end
  end

endmodule

// File: rtl/priv_return_unit_chk.sv
module priv_return_unit_chk
  import prt_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_op,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] status_in,
  input logic            done,
  input logic            commit,
  input logic            illegal,
  input logic            misaligned,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] fault_addr,
  input logic            status_we,
  input logic [XLEN-1:0] status_out,
  input logic            s_trap_we
);

  a_r1_single_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones({commit, illegal, misaligned}) == 1));

  a_r1_done_follows_req: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_valid));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!commit && !illegal && !misaligned && !status_we && !s_trap_we));

  a_r2_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!status_we && !s_trap_we && next_pc == $past(cur_pc)));

  a_r7_misaligned_hold: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (!status_we && !s_trap_we &&
                    fault_addr == $past(cur_pc) && next_pc == $past(cur_pc)));

  a_r4_commit_aligned: assert property (@(posedge clk) disable iff (rst)
    commit |-> (next_pc[ALIGN_BITS-1:0] == '0));

  a_r3_redirect_to_super: assert property (@(posedge clk) disable iff (rst)
    (commit && !$past(req_op)) |->
      (s_trap_we && status_out[PRV0_LO +: PRV_W] == PRV_SUPER));

  a_r8_pop_refill: assert property (@(posedge clk) disable iff (rst)
    (commit && $past(req_op)) |->
      (!s_trap_we && status_out[IE2_BIT] &&
       status_out[PRV2_LO +: PRV_W] == PRV_USER &&
       status_out[PRV0_LO +: PRV_W] == $past(status_in[PRV1_LO +: PRV_W])));

endmodule

bind priv_return_unit priv_return_unit_chk #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .cur_pc     (cur_pc),
  .status_in  (status_in),
  .done       (done),
  .commit     (commit),
  .illegal    (illegal),
  .misaligned (misaligned),
  .next_pc    (next_pc),
  .fault_addr (fault_addr),
  .status_we  (status_we),
  .status_out (status_out),
  .s_trap_we  (s_trap_we)
);

// File: tb/priv_return_unit_bench.sv
module priv_return_unit_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int XLEN = 32;

  typedef struct packed {
    logic        op;
    logic [8:0]  st;
    logic [31:0] tvec;
    logic [31:0] sepc;
    logic [31:0] mepc;
    logic [1:0]  kind;   // 0 commit, 1 illegal, 2 misaligned
  } vec_t;

  function automatic logic [8:0] mkst(input logic [1:0] p2, input logic i2,
                                      input logic [1:0] p1, input logic i1,
                                      input logic [1:0] p0, input logic i0);
    return {p2, i2, p1, i1, p0, i0};
  endfunction

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, mkst(2'd0,1'b1,2'd1,1'b0,2'd3,1'b1), 32'h0000_0100, 32'h0000_2000, 32'h0000_3000, 2'd0},
    '{1'b0, mkst(2'd0,1'b1,2'd3,1'b0,2'd1,1'b1), 32'h0000_0100, 32'h0000_2000, 32'h0000_3000, 2'd1},
    '{1'b0, mkst(2'd0,1'b1,2'd1,1'b0,2'd3,1'b0), 32'h0000_0102, 32'h0000_2000, 32'h0000_3000, 2'd2},
    '{1'b0, mkst(2'd0,1'b1,2'd1,1'b0,2'd3,1'b0), 32'h0000_0101, 32'h0000_2000, 32'h0000_3000, 2'd2},
    '{1'b1, mkst(2'd3,1'b0,2'd0,1'b1,2'd1,1'b0), 32'h0000_0100, 32'h0000_2000, 32'h0000_3001, 2'd0},
    '{1'b1, mkst(2'd1,1'b1,2'd2,1'b0,2'd3,1'b1), 32'h0000_0100, 32'h0000_2002, 32'h0000_3000, 2'd0},
    '{1'b1, mkst(2'd0,1'b1,2'd1,1'b0,2'd0,1'b1), 32'h0000_0100, 32'h0000_2000, 32'h0000_3000, 2'd1},
    '{1'b1, mkst(2'd0,1'b1,2'd1,1'b0,2'd2,1'b1), 32'h0000_0100, 32'h0000_2000, 32'h0000_3000, 2'd1},
    '{1'b1, mkst(2'd0,1'b1,2'd1,1'b0,2'd3,1'b1), 32'h0000_0100, 32'h0000_2000, 32'h0000_3002, 2'd2},
    '{1'b1, mkst(2'd0,1'b1,2'd1,1'b0,2'd1,1'b1), 32'h0000_0100, 32'h0000_2001, 32'h0000_3000, 2'd2},
    '{1'b1, mkst(2'd2,1'b1,2'd1,1'b1,2'd3,1'b0), 32'h0000_0100, 32'h0000_2003, 32'h0000_3004, 2'd0}
  };

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid;
  logic            req_op;
  logic [XLEN-1:0] cur_pc, status_in, m_epc, m_cause, m_badaddr, s_epc, s_tvec;
  logic            done, commit, illegal, misaligned, status_we, s_trap_we;
  logic [XLEN-1:0] next_pc, fault_addr, status_out, s_epc_out, s_cause_out, s_badaddr_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  priv_return_unit #(.XLEN(XLEN)) u_priv_return_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .cur_pc(cur_pc), .status_in(status_in), .m_epc(m_epc), .m_cause(m_cause),
    .m_badaddr(m_badaddr), .s_epc(s_epc), .s_tvec(s_tvec),
    .done(done), .commit(commit), .illegal(illegal), .misaligned(misaligned),
    .next_pc(next_pc), .fault_addr(fault_addr), .status_we(status_we),
    .status_out(status_out), .s_trap_we(s_trap_we), .s_epc_out(s_epc_out),
    .s_cause_out(s_cause_out), .s_badaddr_out(s_badaddr_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // drive one request at a negedge; result is checked at the next negedge
  task automatic drive(input logic op, input logic [31:0] st, input logic [31:0] tv,
                       input logic [31:0] se, input logic [31:0] me, input logic [31:0] pc);
    req_valid = 1'b1; req_op = op; status_in = st; s_tvec = tv;
    s_epc = se; m_epc = me; cur_pc = pc;
    m_cause = 32'h8000_0007 ^ pc; m_badaddr = 32'hBAD0_0000 ^ pc;
  endtask

  task automatic check_result(input logic op, input logic [31:0] st, input logic [31:0] tv,
                              input logic [31:0] se, input logic [31:0] me, input logic [31:0] pc,
                              input logic [1:0] kind_exp_tab);
    logic [1:0]  p0;
    logic [1:0]  kind;
    logic [31:0] tgt;
    logic [31:0] exp_st;
    p0 = st[2:1];
    if (op == 1'b0) begin
      tgt  = tv;
      kind = (p0 != 2'd3) ? 2'd1 : ((tgt[1:0] != 2'b00) ? 2'd2 : 2'd0);
      exp_st = {st[31:3], 2'd1, st[0]};
    end else begin
      tgt  = (p0 == 2'd1) ? se : me;
      kind = (p0 != 2'd1 && p0 != 2'd3) ? 2'd1 : ((tgt[1:0] != 2'b00) ? 2'd2 : 2'd0);
      exp_st = {st[31:9], 2'd0, 1'b1, st[8:7], st[6], st[5:4], st[3]};
    end
    chk("R1 kind table", {30'd0, kind}, {30'd0, kind_exp_tab});
    chk("R1 done", {31'd0, done}, 32'd1);
    chk("R1 commit", {31'd0, commit}, {31'd0, kind == 2'd0});
    chk(op ? "R5 illegal" : "R2 illegal", {31'd0, illegal}, {31'd0, kind == 2'd1});
    chk(op ? "R7 misaligned" : "R4 misaligned", {31'd0, misaligned}, {31'd0, kind == 2'd2});
    chk(op ? "R6 next_pc" : "R4 next_pc", next_pc, (kind == 2'd0) ? tgt : pc);
    chk("R7 status_we", {31'd0, status_we}, {31'd0, kind == 2'd0});
    chk("R3 s_trap_we", {31'd0, s_trap_we}, {31'd0, kind == 2'd0 && op == 1'b0});
    if (kind == 2'd2) chk("R4 fault_addr", fault_addr, pc);
    if (kind == 2'd0) begin
      chk(op ? "R8 status pop" : "R3 status prv", status_out, exp_st);
      if (op == 1'b0) begin
        chk("R3 s_epc copy", s_epc_out, me);
        chk("R3 s_cause copy", s_cause_out, 32'h8000_0007 ^ pc);
        chk("R3 s_badaddr copy", s_badaddr_out, 32'hBAD0_0000 ^ pc);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = 1'b0;
    cur_pc = '0; status_in = '0; m_epc = '0; m_cause = '0; m_badaddr = '0;
    s_epc = '0; s_tvec = '0;
    repeat (3) @(negedge clk);
    // R9: request during reset is dropped
    drive(1'b0, 32'h0000_0007, 32'h100, 32'h200, 32'h300, 32'h40);
    @(negedge clk);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    chk("R9 reset flags", {28'd0, commit, illegal, misaligned, status_we}, 32'd0);
    chk("R9 reset next_pc", next_pc, 32'd0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle after reset", {26'd0, done, commit, illegal, misaligned, status_we, s_trap_we}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] st;
      logic [31:0] pc;
      st = 32'hA5A5_A000 | {23'd0, VECS[i].st};
      pc = 32'h0001_0000 + 32'(i * 4);
      drive(VECS[i].op, st, VECS[i].tvec, VECS[i].sepc, VECS[i].mepc, pc);
      @(negedge clk);
      req_valid = 1'b0;
      check_result(VECS[i].op, st, VECS[i].tvec, VECS[i].sepc, VECS[i].mepc, pc, VECS[i].kind);
      @(negedge clk);
      chk("R10 idle gap", {26'd0, done, commit, illegal, misaligned, status_we, s_trap_we}, 32'd0);
    end

    // back-to-back: redirect then return, each answered in its own cycle (R1)
    drive(1'b0, 32'h0000_0017, 32'h0000_0400, 32'h0, 32'h0, 32'h0002_0000);
    @(negedge clk);
    check_result(1'b0, 32'h0000_0017, 32'h0000_0400, 32'h0, 32'h0, 32'h0002_0000, 2'd0);
    drive(1'b1, 32'h0000_01D3, 32'h0, 32'h0000_0800, 32'h0000_0900, 32'h0002_0004);
    @(negedge clk);
    req_valid = 1'b0;
    check_result(1'b1, 32'h0000_01D3, 32'h0, 32'h0000_0800, 32'h0000_0900, 32'h0002_0004, 2'd0);

    // reset mid-stream clears outputs (R9)
    drive(1'b1, 32'h0000_0003, 32'h0, 32'h0000_0800, 32'h0, 32'h0002_0008);
    rst = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 reset clears done", {31'd0, done}, 32'd0);
    chk("R9 reset clears we", {30'd0, status_we, s_trap_we}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    summary();
  end

endmodule